// File: doc/BRIEF.md
# Protected Address Translation Cache

This block is a small fully associative cache of page translations for a system with 4 KB pages. It turns a virtual address into a physical address in the same cycle as the request by comparing the virtual page number against every stored entry at once. The 12 offset bits under the page number are not translated and go straight through to the physical address.

Each entry carries its own read, write and execute rights, in any combination, plus a flag that limits the page to kernel mode. Each lookup checks the requested kind of access and the current processor mode against that entry and raises a protection fault when the access is not allowed. The block also tracks a per-entry dirty flag. The first permitted write to a clean page raises a one-cycle request, so that whatever owns the page table can mark the backing entry as modified. The block then sets its own copy of the flag, and later writes to that page raise no request.

Entries are loaded from a page walker through a fill port. Free entries are used first. Once every entry is valid, a clock-style pointer with per-entry reference bits picks the entry to replace. A flush input clears every entry, for example on a context switch.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, and after any flush, every lookup reports miss=1 and hit=0 until a new fill is made.
- R2: A lookup whose page number (address bits above bit 11) matches a valid entry asserts hit=1 and miss=0 in the same cycle. It drives paddr as the entry's frame number placed above the 12 offset bits.
- R3: The low 12 address bits appear unchanged as the low 12 bits of paddr on every hit.
- R4: A lookup that matches no valid entry asserts miss=1 and keeps hit, fault and dirty_req at 0.
- R5: lk_acc encodes 0 read, 1 write, 2 execute, and 3 is treated as read. On a hit, fault=1 when the entry's permission bit for the requested access is clear.
- R6: On a hit with lk_user=1 and an entry marked kernel-only, fault=1 whatever the permission bits are. With lk_user=0 the kernel-only mark has no effect.
- R7: A non-faulting write hit on an entry whose dirty flag is clear asserts dirty_req=1 in that cycle and sets the flag at the clock edge, so later writes to that page give dirty_req=0. Reads, executes and faulting writes never assert dirty_req.
- R8: flush=1 invalidates all entries at the clock edge. When flush and fill_valid are both high in the same cycle, the flush wins and the fill is discarded.
- R9: While any entry is invalid, a fill writes the lowest-numbered invalid entry and leaves the replacement pointer where it is.
- R10: When all entries are valid, a fill starts at the replacement pointer and moves forward circularly. It clears the reference bit of each entry it passes that has the bit set, and replaces the first entry whose bit is clear. If every bit was set, all are cleared and the entry at the pointer is replaced. The pointer then moves to the entry after the one replaced.
- R11: A fill sets the reference bit of the entry it writes, and every lookup hit sets the reference bit of the entry that matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_user | input | 1 | 1 when the processor is in user mode |
| fill_valid | input | 1 | Write a new translation |
| fill_vpn | input | VA_W-12 | Virtual page number of the new translation |
| fill_pfn | input | PA_W-12 | Physical frame number of the new translation |
| fill_r | input | 1 | Read allowed |
| fill_w | input | 1 | Write allowed |
| fill_x | input | 1 | Execute allowed |
| fill_kern | input | 1 | Page is kernel-only |
| fill_dirty | input | 1 | Initial dirty flag |
| hit | output | 1 | Lookup matched a valid entry |
| miss | output | 1 | Lookup matched no valid entry |
| fault | output | 1 | Matched access is not permitted |
| dirty_req | output | 1 | First write to a clean page |
| paddr | output | PA_W | Translated physical address |

## Verification
The bench builds the block with 4 entries, a 20-bit virtual address and a 24-bit physical address. This keeps page numbers to 8 bits and frame numbers to 12 bits. With so few entries, a handful of fills exhausts the free slots and forces the clock pointer through a full wrap and a partial sweep, which makes the exact replacement order observable at the ports. The small size also makes an exhaustive sweep affordable: all 16 combinations of read, write, execute and kernel-only, times the three access kinds and both modes. The expected fault and address for each case are computed arithmetically in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
        logic kern;
    } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic                          match_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (vpn_i[g] == key_i);
    end

    always_comb begin
        match_o = |eq;
        idx_o   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  perm_t      perm_i,
    input  logic [1:0] acc_i,
    input  logic       user_i,
    output logic       fault_o
);
    logic allowed;

    always_comb begin
        unique case (acc_e'(acc_i))
            ACC_WRITE: allowed = perm_i.w;
            ACC_EXEC:  allowed = perm_i.x;
            default:   allowed = perm_i.r;
        endcase
        fault_o = !allowed || (user_i && perm_i.kern);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] refb_i,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic               use_clock_o,
    output logic [IDX_W-1:0]   victim_o,
    output logic [ENTRIES-1:0] refb_clr_o,
    output logic [IDX_W-1:0]   ptr_next_o
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] clk_idx;
    logic             found;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
        use_clock_o = &valid_i;

        found      = 1'b0;
        clk_idx    = ptr_i;
        refb_clr_o = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            int j;
            j = (int'(ptr_i) + k) % ENTRIES;
            if (!found) begin
                if (refb_i[j]) begin
                    refb_clr_o[j] = 1'b1;
                end else begin
                    found   = 1'b1;
                    clk_idx = IDX_W'(j);
                end
            end
        end

        victim_o   = use_clock_o ? clk_idx : free_idx;
        ptr_next_o = IDX_W'((int'(clk_idx) + 1) % ENTRIES);
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             lk_user,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_r,
    input  logic             fill_w,
    input  logic             fill_x,
    input  logic             fill_kern,
    input  logic             fill_dirty,
    output logic             hit,
    output logic             miss,
    output logic             fault,
    output logic             dirty_req,
    output logic [PA_W-1:0]  paddr
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            refb;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        perm_t [ENTRIES-1:0]           perm;
        logic [IDX_W-1:0]              ptr;
    } state_t;

    state_t s_d, s_q;

    logic               match;
    logic [IDX_W-1:0]   hit_idx;
    logic               perm_fault;
    logic               use_clock;
    logic [IDX_W-1:0]   victim;
    logic [ENTRIES-1:0] refb_clr;
    logic [IDX_W-1:0]   ptr_next;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) match_i (
        .valid_i (s_q.valid),
        .vpn_i   (s_q.vpn),
        .key_i   (lk_vaddr[VA_W-1:PAGE_BITS]),
        .match_o (match),
        .idx_o   (hit_idx)
    );

    tlb_perm perm_i (
        .perm_i  (s_q.perm[hit_idx]),
        .acc_i   (lk_acc),
        .user_i  (lk_user),
        .fault_o (perm_fault)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .valid_i     (s_q.valid),
        .refb_i      (s_q.refb),
        .ptr_i       (s_q.ptr),
        .use_clock_o (use_clock),
        .victim_o    (victim),
        .refb_clr_o  (refb_clr),
        .ptr_next_o  (ptr_next)
    );

    always_comb begin
        s_d = s_q;

        hit       = lk_valid && match;
        miss      = lk_valid && !match;
        fault     = hit && perm_fault;
        dirty_req = hit && !perm_fault && (acc_e'(lk_acc) == ACC_WRITE)
                    && !s_q.dirty[hit_idx];
        paddr     = {s_q.pfn[hit_idx], lk_vaddr[PAGE_BITS-1:0]};

        if (fill_valid && use_clock) begin
            s_d.refb = s_d.refb & ~refb_clr;
            s_d.ptr  = ptr_next;
        end
        if (hit) s_d.refb[hit_idx] = 1'b1;
        if (dirty_req) s_d.dirty[hit_idx] = 1'b1;

        if (fill_valid) begin
            s_d.valid[victim] = 1'b1;
            s_d.refb[victim]  = 1'b1;
            s_d.dirty[victim] = fill_dirty;
            s_d.vpn[victim]   = fill_vpn;
            s_d.pfn[victim]   = fill_pfn;
            s_d.perm[victim]  = '{r: fill_r, w: fill_w, x: fill_x, kern: fill_kern};
        end

        if (flush) begin
            s_d.valid = '0;
            s_d.refb  = '0;
            s_d.ptr   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            fill_valid,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic [1:0]      lk_acc,
    input logic            hit,
    input logic            miss,
    input logic            fault,
    input logic            dirty_req,
    input logic [PA_W-1:0] paddr
);
    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    // R2
    lookup_resolves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (hit || miss));

    // R5
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> hit);

    // R7
    dirty_req_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_req |-> (hit && !fault && lk_acc == 2'd1));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

    // R7
    dirty_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_req && !flush && !fill_valid) |=>
        !(dirty_req && lk_vaddr[VA_W-1:PAGE_BITS] == $past(lk_vaddr[VA_W-1:PAGE_BITS])));
endmodule

bind xlat_tlb tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) chk_i (.*);

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb_top;
    localparam int ENTRIES = 4;
    localparam int VA_W    = 20;
    localparam int PA_W    = 24;
    localparam int PB      = 12;
    localparam int VPN_W   = VA_W - PB;
    localparam int PFN_W   = PA_W - PB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, lk_valid = 1'b0, lk_user = 1'b0, fill_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [1:0] lk_acc = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic fill_r = 1'b0, fill_w = 1'b0, fill_x = 1'b0, fill_kern = 1'b0, fill_dirty = 1'b0;
    logic hit, miss, fault, dirty_req;
    logic [PA_W-1:0] paddr;

    int checks = 0;
    int errors = 0;
    logic o_hit, o_miss, o_fault, o_dreq;
    logic [PA_W-1:0] o_pa;

    always #5 clk = ~clk;

    xlat_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] acc, input logic usr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr;
        #2;
        o_hit = hit; o_miss = miss; o_fault = fault; o_dreq = dirty_req; o_pa = paddr;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                        input logic r, input logic w, input logic x,
                        input logic k, input logic d, input logic fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_r = r; fill_w = w; fill_x = x; fill_kern = k; fill_dirty = d;
        flush = fl;
        @(posedge clk);
        #1 fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic expect_miss(input string tag, input logic [VPN_W-1:0] vpn);
        look({vpn, 12'h0}, 2'd0, 1'b0);
        chk({tag, " miss"}, 32'(o_miss), 32'd1);
        chk({tag, " hit"}, 32'(o_hit), 32'd0);
    endtask

    task automatic expect_hit(input string tag, input logic [VPN_W-1:0] vpn,
                              input logic [PFN_W-1:0] pfn);
        look({vpn, 12'h5A5}, 2'd0, 1'b0);
        chk({tag, " hit"}, 32'(o_hit), 32'd1);
        chk({tag, " paddr"}, 32'(o_pa), 32'({pfn, 12'h5A5}));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R4: empty after reset
        look(20'h12345, 2'd0, 1'b0);
        chk("R1 reset miss", 32'(o_miss), 32'd1);
        chk("R1 reset hit", 32'(o_hit), 32'd0);
        chk("R4 reset fault", 32'(o_fault), 32'd0);

        // R2 R3 R5 R6: exhaustive permission sweep
        for (int c = 0; c < 16; c++) begin
            logic r, w, x, k;
            logic [VPN_W-1:0] vpn;
            logic [PFN_W-1:0] pfn;
            r = c[3]; w = c[2]; x = c[1]; k = c[0];
            vpn = VPN_W'(8'h10 + c);
            pfn = PFN_W'(12'h100 + c * 7);
            fill(vpn, pfn, r, w, x, k, 1'b1, 1'b0);
            for (int a = 0; a < 4; a++) begin
                for (int u = 0; u < 2; u++) begin
                    logic pb, ef;
                    logic [11:0] off;
                    off = 12'((c * 37 + a * 5 + u * 1000) % 4096);
                    pb = (a == 1) ? w : (a == 2) ? x : r;
                    ef = !pb || (u == 1 && k);
                    look({vpn, off}, 2'(a), 1'(u));
                    chk("R2 sweep hit", 32'(o_hit), 32'd1);
                    chk("R2 sweep miss", 32'(o_miss), 32'd0);
                    chk("R5 R6 sweep fault", 32'(o_fault), 32'(ef));
                    chk("R7 sweep dirty_req on dirty page", 32'(o_dreq), 32'd0);
                    if (!ef) chk("R3 sweep paddr", 32'(o_pa), 32'({pfn, off}));
                end
            end
        end

        // R4: unmatched page
        look({8'hEE, 12'h001}, 2'd1, 1'b1);
        chk("R4 miss", 32'(o_miss), 32'd1);
        chk("R4 hit", 32'(o_hit), 32'd0);
        chk("R4 fault", 32'(o_fault), 32'd0);
        chk("R4 dirty_req", 32'(o_dreq), 32'd0);

        // R7: dirty request behaviour
        do_flush();
        fill(8'h40, 12'hA40, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        look({8'h40, 12'h010}, 2'd0, 1'b1);
        chk("R7 read no dirty_req", 32'(o_dreq), 32'd0);
        look({8'h40, 12'h010}, 2'd2, 1'b1);
        chk("R5 exec fault", 32'(o_fault), 32'd1);
        chk("R7 exec no dirty_req", 32'(o_dreq), 32'd0);
        look({8'h40, 12'h020}, 2'd1, 1'b1);
        chk("R7 first write dirty_req", 32'(o_dreq), 32'd1);
        chk("R7 first write no fault", 32'(o_fault), 32'd0);
        look({8'h40, 12'h030}, 2'd1, 1'b1);
        chk("R7 second write no dirty_req", 32'(o_dreq), 32'd0);
        fill(8'h41, 12'hA41, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        look({8'h41, 12'h000}, 2'd1, 1'b0);
        chk("R7 faulting write fault", 32'(o_fault), 32'd1);
        chk("R7 faulting write no dirty_req", 32'(o_dreq), 32'd0);
        fill(8'h42, 12'hA42, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        look({8'h42, 12'h000}, 2'd1, 1'b1);
        chk("R6 user on kernel page fault", 32'(o_fault), 32'd1);
        chk("R7 user kernel-page no dirty_req", 32'(o_dreq), 32'd0);
        look({8'h42, 12'h000}, 2'd1, 1'b0);
        chk("R6 kernel mode no fault", 32'(o_fault), 32'd0);
        chk("R7 kernel write dirty_req", 32'(o_dreq), 32'd1);

        // R8: flush, and flush beating a same-cycle fill
        do_flush();
        expect_miss("R8 after flush 0x40", 8'h40);
        expect_miss("R1 after flush 0x42", 8'h42);
        fill(8'h60, 12'hB60, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        fill(8'h61, 12'hB61, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        expect_miss("R8 flush drops old 0x60", 8'h60);
        expect_miss("R8 flush wins over fill 0x61", 8'h61);

        // R9 R10 R11: replacement order
        do_flush();
        for (int i = 0; i < 4; i++)
            fill(VPN_W'(8'h50 + i), PFN_W'(12'hC50 + i), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)
            expect_hit("R9 free slots fill", VPN_W'(8'h50 + i), PFN_W'(12'hC50 + i));
        fill(8'h54, 12'hC54, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        look({8'h52, 12'h000}, 2'd0, 1'b0);
        chk("R11 hit on C", 32'(o_hit), 32'd1);
        fill(8'h55, 12'hC55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        fill(8'h56, 12'hC56, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_miss("R10 wrap evicts A", 8'h50);
        expect_miss("R10 next clear evicts B", 8'h51);
        expect_miss("R11 referenced C skipped, D evicted", 8'h53);
        expect_hit("R11 C kept", 8'h52, 12'hC52);
        expect_hit("R10 E present", 8'h54, 12'hC54);
        expect_hit("R10 F present", 8'h55, 12'hC55);
        expect_hit("R10 G present", 8'h56, 12'hC56);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule